// File: doc/BRIEF.md
# Sequential-Access Coefficient RAM Port

This block gives a host bus indirect access to two coefficient memories of a filter engine: a gain memory of full 32-bit words and a shift memory that keeps only five bits per entry. Each memory sits behind its own pair of registers. The control register sets a pointer, an access direction and an auto-increment mode. The data register moves one word per access at the pointer. A whole block of coefficients is loaded or saved by writing the control register once and then hitting the same data register repeatedly.

The host side is a pair of one-cycle strobes. A write strobe carries a register selector and a 32-bit word. A read strobe carries a selector, and its answer comes back registered in the next cycle with a valid flag. Reads and writes may be issued in the same cycle. Reading a data register has a side effect, because it moves the pointer. Reading a control register has none.

Top module: `coef_access_hub`

## Requirements
- R1: After reset, both control registers read back 0x00004000: auto-increment on, read direction, pointer 0. `rd_valid` and `rd_data` are 0.
- R2: Selector codes are 0 for gain control, 1 for gain data, 2 for shift control and 3 for shift data. Control word fields are: bits [11:0] address, bit 12 direction (1 = write, 0 = read), bit 13 pointer-load enable, bit 14 auto-increment enable.
- R3: A control write with bit 13 set loads the pointer from the address field. An address at or beyond the memory depth (496 gain words, 112 shift entries) loads 0 instead.
- R4: A control write with bit 13 clear updates the direction and auto-increment bits and leaves the pointer unchanged.
- R5: A data write in write direction stores the word at the pointer. The shift memory keeps only bits [4:0].
- R6: A data read in read direction returns the word at the pointer and advances the pointer exactly once when auto-increment is on.
- R7: With auto-increment off, data accesses transfer a word but never move the pointer.
- R8: A data write in read direction, or a data read in write direction, is ignored and leaves the pointer unchanged. Such a read returns 0.
- R9: The pointer wraps from the last location of its memory to 0.
- R10: A control read returns the current pointer in bits [11:0], the direction in bit 12 and the auto-increment bit in bit 14. Bit 13 reads 0.
- R11: When a control write and a data access to the same memory fall in one cycle, the data access uses the direction and pointer from before the write. The control write alone decides the next pointer.
- R12: `rd_valid` is high in exactly the cycle after each read strobe, with `rd_data` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selector for the write |
| wr_data | input | 32 | Write word |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Register selector for the read |
| rd_data | output | 32 | Read word, registered |
| rd_valid | output | 1 | High the cycle after a read strobe |

## Verification
A control write and a data access to the same memory can land in one cycle, because the host has separate write and read strobes. The bench provokes this by writing the gain control register with a pointer load while it reads the gain data register in the same cycle. The returned word must come from the old pointer. The pointer must then read back as the loaded address and not one past it. A following data read must return the word stored at the loaded address.

// File: rtl/coef_port_pkg.sv
package coef_port_pkg;

  localparam int unsigned BUS_W        = 32;
  localparam int unsigned CTL_ADDR_W   = 12;
  localparam int unsigned CTL_DIR_BIT  = 12;
  localparam int unsigned CTL_LOAD_BIT = 13;
  localparam int unsigned CTL_SEQ_BIT  = 14;
  localparam int unsigned CTL_USED_W   = CTL_SEQ_BIT + 1;
  localparam logic [BUS_W-1:0] CTL_RESET_WORD = 32'h0000_4000;

  typedef enum logic [1:0] {
    SEL_GAIN_CTL  = 2'd0,
    SEL_GAIN_DAT  = 2'd1,
    SEL_SHIFT_CTL = 2'd2,
    SEL_SHIFT_DAT = 2'd3
  } reg_sel_e;

  // next pointer after one sequential transfer
  function automatic int unsigned wrap_inc(int unsigned cur, int unsigned depth);
    return (cur + 1 >= depth) ? 0 : cur + 1;
  endfunction

  // pointer value taken from a load request
  function automatic int unsigned load_target(int unsigned addr, int unsigned depth);
    return (addr < depth) ? addr : 0;
  endfunction

  // control readback layout
  function automatic logic [BUS_W-1:0] pack_ctl(logic seq, logic dir_wr,
                                                logic [CTL_ADDR_W-1:0] addr);
    logic [BUS_W-1:0] w;
    w = '0;
    w[CTL_ADDR_W-1:0] = addr;
    w[CTL_DIR_BIT]    = dir_wr;
    w[CTL_SEQ_BIT]    = seq;
    return w;
  endfunction

endpackage

// File: rtl/coef_ptr_ctrl.sv
module coef_ptr_ctrl
  import coef_port_pkg::*;
#(
  parameter int unsigned DEPTH = 496,
  parameter int unsigned PTR_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctrl_wr,
  input  logic [CTL_USED_W-1:0] ctl_word,
  input  logic                  data_wr,
  input  logic                  data_rd,
  output logic [PTR_W-1:0]      ptr,
  output logic                  dir_wr,
  output logic                  seq_on,
  output logic                  ev_ctl,
  output logic                  ev_adv,
  output logic                  wr_fire,
  output logic                  rd_fire
);

  logic load_req;
  logic [PTR_W-1:0] load_val;
  logic [PTR_W-1:0] inc_val;

  assign load_req = ctrl_wr && ctl_word[CTL_LOAD_BIT];
  assign wr_fire  = data_wr && dir_wr;
  assign rd_fire  = data_rd && !dir_wr;
  assign ev_ctl   = ctrl_wr;
  assign ev_adv   = seq_on && (wr_fire || rd_fire);
  assign load_val = PTR_W'(load_target(32'(ctl_word[CTL_ADDR_W-1:0]), DEPTH));
  assign inc_val  = PTR_W'(wrap_inc(32'(ptr), DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      dir_wr <= CTL_RESET_WORD[CTL_DIR_BIT];
      seq_on <= CTL_RESET_WORD[CTL_SEQ_BIT];
    end else if (ctrl_wr) begin
      dir_wr <= ctl_word[CTL_DIR_BIT];
      seq_on <= ctl_word[CTL_SEQ_BIT];
      if (load_req) ptr <= load_val;
    end else if (ev_adv) begin
      ptr <= inc_val;
    end
  end

endmodule

// File: rtl/coef_store.sv
module coef_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 496,
  parameter int unsigned PTR_W  = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/coef_ram_port.sv
module coef_ram_port
  import coef_port_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 496,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             data_wr,
  input  logic             data_rd,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] ctl_view,
  output logic [BUS_W-1:0] data_view,
  output logic [PTR_W-1:0] ptr_o,
  output logic             dir_o,
  output logic             ev_ctl,
  output logic             ev_adv
);

  logic              seq_on;
  logic              wr_fire;
  logic              rd_fire;
  logic [DATA_W-1:0] mem_word;
  logic [BUS_W-1:0]  word_ext;

  coef_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) ptr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .ctl_word(wdata[CTL_USED_W-1:0]),
    .data_wr (data_wr),
    .data_rd (data_rd),
    .ptr     (ptr_o),
    .dir_wr  (dir_o),
    .seq_on  (seq_on),
    .ev_ctl  (ev_ctl),
    .ev_adv  (ev_adv),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire)
  );

  coef_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) store_i (
    .clk  (clk),
    .we   (wr_fire),
    .addr (ptr_o),
    .wdata(wdata[DATA_W-1:0]),
    .rdata(mem_word)
  );

  generate
    if (DATA_W < BUS_W) begin : g_narrow
      logic unused_hi;
      assign unused_hi = ^{wdata[BUS_W-1:DATA_W], rd_fire};
      assign word_ext  = {{(BUS_W-DATA_W){1'b0}}, mem_word};
    end else begin : g_full
      logic unused_rd;
      assign unused_rd = rd_fire;
      assign word_ext  = mem_word[BUS_W-1:0];
    end
  endgenerate

  assign ctl_view  = pack_ctl(seq_on, dir_o, CTL_ADDR_W'(ptr_o));
  assign data_view = dir_o ? '0 : word_ext;

endmodule

// File: rtl/coef_access_hub.sv
module coef_access_hub
  import coef_port_pkg::*;
#(
  parameter int unsigned GAIN_W          = 32,
  parameter int unsigned SHIFT_W         = 5,
  parameter int unsigned CHANNELS        = 8,
  parameter int unsigned GAIN_PER_CHAN   = 62,
  parameter int unsigned SHIFT_PER_CHAN  = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        rd_valid
);

  localparam int unsigned GAIN_DEPTH  = CHANNELS * GAIN_PER_CHAN;
  localparam int unsigned SHIFT_DEPTH = CHANNELS * SHIFT_PER_CHAN;
  localparam int unsigned GP_W        = $clog2(GAIN_DEPTH);
  localparam int unsigned SP_W        = $clog2(SHIFT_DEPTH);

  // decoded strobes
  logic gain_ctl_wr, gain_dat_wr, gain_dat_rd;
  logic shift_ctl_wr, shift_dat_wr, shift_dat_rd;

  assign gain_ctl_wr  = wr_en && (wr_sel == SEL_GAIN_CTL);
  assign gain_dat_wr  = wr_en && (wr_sel == SEL_GAIN_DAT);
  assign shift_ctl_wr = wr_en && (wr_sel == SEL_SHIFT_CTL);
  assign shift_dat_wr = wr_en && (wr_sel == SEL_SHIFT_DAT);
  assign gain_dat_rd  = rd_en && (rd_sel == SEL_GAIN_DAT);
  assign shift_dat_rd = rd_en && (rd_sel == SEL_SHIFT_DAT);

  // per-memory views and events
  logic [31:0]     gain_ctl_view, gain_dat_view, shift_ctl_view, shift_dat_view;
  logic [GP_W-1:0] gain_ptr;
  logic [SP_W-1:0] shift_ptr;
  logic            gain_dir, shift_dir;
  logic            gain_ev_ctl, gain_ev_adv, shift_ev_ctl, shift_ev_adv;

  coef_ram_port #(.DATA_W(GAIN_W), .DEPTH(GAIN_DEPTH)) gain_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr  (gain_ctl_wr),
    .data_wr  (gain_dat_wr),
    .data_rd  (gain_dat_rd),
    .wdata    (wr_data),
    .ctl_view (gain_ctl_view),
    .data_view(gain_dat_view),
    .ptr_o    (gain_ptr),
    .dir_o    (gain_dir),
    .ev_ctl   (gain_ev_ctl),
    .ev_adv   (gain_ev_adv)
  );

  coef_ram_port #(.DATA_W(SHIFT_W), .DEPTH(SHIFT_DEPTH)) shift_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr  (shift_ctl_wr),
    .data_wr  (shift_dat_wr),
    .data_rd  (shift_dat_rd),
    .wdata    (wr_data),
    .ctl_view (shift_ctl_view),
    .data_view(shift_dat_view),
    .ptr_o    (shift_ptr),
    .dir_o    (shift_dir),
    .ev_ctl   (shift_ev_ctl),
    .ev_adv   (shift_ev_adv)
  );

  // registered read return
  logic [31:0] rd_mux;

  always_comb begin
    unique case (rd_sel)
      SEL_GAIN_CTL:  rd_mux = gain_ctl_view;
      SEL_GAIN_DAT:  rd_mux = gain_dat_view;
      SEL_SHIFT_CTL: rd_mux = shift_ctl_view;
      default:       rd_mux = shift_dat_view;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

endmodule

// File: rtl/coef_access_hub_chk.sv
module coef_access_hub_chk
  import coef_port_pkg::*;
#(
  parameter int unsigned GAIN_DEPTH  = 496,
  parameter int unsigned SHIFT_DEPTH = 112,
  parameter int unsigned GP_W        = 9,
  parameter int unsigned SP_W        = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [1:0]      wr_sel,
  input logic [31:0]     wr_data,
  input logic            rd_en,
  input logic [1:0]      rd_sel,
  input logic [31:0]     rd_data,
  input logic            rd_valid,
  input logic [GP_W-1:0] gain_ptr,
  input logic [SP_W-1:0] shift_ptr,
  input logic            gain_dir,
  input logic            gain_ev_ctl,
  input logic            gain_ev_adv,
  input logic            shift_ev_ctl,
  input logic            shift_ev_adv
);

  // R3
  gain_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_GAIN_CTL && wr_data[CTL_LOAD_BIT] &&
     32'(wr_data[CTL_ADDR_W-1:0]) < GAIN_DEPTH)
    |=> gain_ptr == $past(wr_data[GP_W-1:0]));

  // R3
  gain_load_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_GAIN_CTL && wr_data[CTL_LOAD_BIT] &&
     32'(wr_data[CTL_ADDR_W-1:0]) >= GAIN_DEPTH)
    |=> gain_ptr == '0);

  // R4
  gain_ctl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_GAIN_CTL && !wr_data[CTL_LOAD_BIT])
    |=> $stable(gain_ptr));

  // R9
  gain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_ev_adv && !gain_ev_ctl)
    |=> gain_ptr == (($past(gain_ptr) == GP_W'(GAIN_DEPTH - 1)) ? '0
                                                               : $past(gain_ptr) + 1'b1));

  // R9
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_ev_adv && !shift_ev_ctl)
    |=> shift_ptr == (($past(shift_ptr) == SP_W'(SHIFT_DEPTH - 1)) ? '0
                                                                 : $past(shift_ptr) + 1'b1));

  // R8
  gain_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_GAIN_DAT && !gain_dir && !(rd_en && rd_sel == SEL_GAIN_DAT))
    |=> $stable(gain_ptr));

  // R8
  gain_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == SEL_GAIN_DAT && gain_dir) |=> rd_data == '0);

  // R12
  rd_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R12
  rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R9
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(gain_ptr) < GAIN_DEPTH) && (32'(shift_ptr) < SHIFT_DEPTH));

endmodule

bind coef_access_hub coef_access_hub_chk #(
  .GAIN_DEPTH (GAIN_DEPTH),
  .SHIFT_DEPTH(SHIFT_DEPTH),
  .GP_W       (GP_W),
  .SP_W       (SP_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .rd_en       (rd_en),
  .rd_sel      (rd_sel),
  .rd_data     (rd_data),
  .rd_valid    (rd_valid),
  .gain_ptr    (gain_ptr),
  .shift_ptr   (shift_ptr),
  .gain_dir    (gain_dir),
  .gain_ev_ctl (gain_ev_ctl),
  .gain_ev_adv (gain_ev_adv),
  .shift_ev_ctl(shift_ev_ctl),
  .shift_ev_adv(shift_ev_adv)
);

// File: tb/coef_access_hub_test.sv
module coef_access_hub_test;

  localparam logic [1:0] GC = 2'd0, GD = 2'd1, SC = 2'd2, SD = 2'd3;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1;
  localparam int NVEC = 18;

  // {op, selector, write word, expected read word}
  localparam logic [67:0] VEC [NVEC] = '{
    {OP_WR, GC, 32'h0000_7005, 32'h0},          // R2 R3 load 5, write dir, seq
    {OP_WR, GD, 32'h1111_1111, 32'h0},          // R5
    {OP_WR, GD, 32'hDEAD_BEEF, 32'h0},          // R5
    {OP_WR, GD, 32'h8000_0001, 32'h0},          // R5
    {OP_RD, GC, 32'h0,         32'h0000_5008},  // R10 pointer advanced 3
    {OP_WR, GC, 32'h0000_6005, 32'h0},          // R3 read dir
    {OP_RD, GD, 32'h0,         32'h1111_1111},  // R6
    {OP_RD, GD, 32'h0,         32'hDEAD_BEEF},  // R6
    {OP_RD, GD, 32'h0,         32'h8000_0001},  // R6
    {OP_RD, GC, 32'h0,         32'h0000_4008},  // R6 R10
    {OP_WR, SC, 32'h0000_706E, 32'h0},          // R3 shift load 110
    {OP_WR, SD, 32'h0000_003F, 32'h0},          // R5 low 5 bits kept
    {OP_WR, SD, 32'h0000_000A, 32'h0},          // R9 last entry
    {OP_RD, SC, 32'h0,         32'h0000_5000},  // R9 wrapped to 0
    {OP_WR, SC, 32'h0000_606E, 32'h0},          // R3
    {OP_RD, SD, 32'h0,         32'h0000_001F},  // R5
    {OP_RD, SD, 32'h0,         32'h0000_000A},  // R6
    {OP_RD, SC, 32'h0,         32'h0000_4000}   // R9
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  coef_access_hub uut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(logic [1:0] sel, logic [31:0] exp, string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    check({tag, " rd_valid"}, 32'(rd_valid), 32'd1);
    check(tag, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rd_valid", 32'(rd_valid), 32'd0);
    check("R1 rd_data", rd_data, 32'd0);
    reg_rd(GC, 32'h0000_4000, "R1 gain ctl");
    reg_rd(SC, 32'h0000_4000, "R1 shift ctl");
    // R12 no read strobe, no valid
    @(negedge clk);
    check("R12 idle", 32'(rd_valid), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][67:66] == OP_WR) reg_wr(VEC[i][65:64], VEC[i][63:32]);
      else reg_rd(VEC[i][65:64], VEC[i][31:0], $sformatf("table row %0d", i));
    end

    // R9 gain wrap at last location
    reg_wr(GC, 32'h0000_71EF);
    reg_wr(GD, 32'hAAAA_0001);
    reg_wr(GD, 32'hBBBB_0002);
    reg_rd(GC, 32'h0000_5001, "R9 gain wrap");
    reg_wr(GC, 32'h0000_61EF);
    reg_rd(GD, 32'hAAAA_0001, "R9 last word");
    reg_rd(GD, 32'hBBBB_0002, "R9 word 0");
    reg_rd(GC, 32'h0000_4001, "R9 ptr");

    // R7 auto-increment off
    reg_wr(GC, 32'h0000_3014);
    reg_wr(GD, 32'h0000_0055);
    reg_wr(GD, 32'h0000_0066);
    reg_rd(GC, 32'h0000_1014, "R7 ptr held on write");
    reg_wr(GC, 32'h0000_2014);
    reg_rd(GD, 32'h0000_0066, "R7 repeat read a");
    reg_rd(GD, 32'h0000_0066, "R7 repeat read b");
    reg_rd(GC, 32'h0000_0014, "R7 ptr held on read");

    // R8 direction mismatch
    reg_wr(GC, 32'h0000_701E);
    reg_wr(GD, 32'h0000_0077);
    reg_rd(GD, 32'h0000_0000, "R8 read in write dir");
    reg_rd(GC, 32'h0000_501F, "R8 ptr after ignored read");
    reg_wr(GC, 32'h0000_601E);
    reg_wr(GD, 32'h0000_0099);
    reg_rd(GC, 32'h0000_401E, "R8 ptr after ignored write");
    reg_rd(GD, 32'h0000_0077, "R8 word untouched");

    // R4 control write without load
    reg_wr(GC, 32'h0000_5000);
    reg_rd(GC, 32'h0000_501F, "R4 ptr kept");
    reg_wr(GC, 32'h0000_4000);
    reg_rd(GC, 32'h0000_401F, "R4 modes only");

    // R3 out-of-range load
    reg_wr(GC, 32'h0000_61F4);
    reg_rd(GC, 32'h0000_4000, "R3 gain range");
    reg_wr(SC, 32'h0000_60C8);
    reg_rd(SC, 32'h0000_4000, "R3 shift range");

    // R11 control write and data read in one cycle
    @(negedge clk);
    wr_en = 1'b1; wr_sel = GC; wr_data = 32'h0000_6005;
    rd_en = 1'b1; rd_sel = GD;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R11 old word", rd_data, 32'hBBBB_0002);
    reg_rd(GC, 32'h0000_4005, "R11 load wins");
    reg_rd(GD, 32'h1111_1111, "R11 next word");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule